// File: doc/BRIEF.md
# Slave-mode video sync decoder

This block is the timing front end of a video encoder running as a timing slave. It samples an external horizontal sync, a combined vertical-sync/field line and an optional blanking input on the pixel clock. From the edges of these pins it derives field-start and frame-start strobes, an odd-field flag, an active-video qualifier and a pixel-capture enable. A small configuration register selects one of four timing modes and master or slave operation, and chooses between the external blanking pin and an internal blanking window.

In the two field-pin modes the line level selects the field, and the state of horizontal sync at the moment the field pin changes decides whether the change counts. In the vertical-sync mode the parity of the new field comes from whether horizontal sync falls in the same cycle as vertical sync. When the external blanking pin is not used, the block counts horizontal sync falls from the last frame start. It blanks every line whose count lies inside a programmable first/last window.

Top module: `vid_sync_slave`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is low. Reset loads timing mode 0, slave operation and internal blanking.
- R2: In mode 1, a change of the field pin in a cycle where horizontal sync is low starts a field, flagged one cycle later. A change while horizontal sync is high is ignored.
- R3: In mode 3, a change of the field pin starts a field only in a cycle where horizontal sync is high. A change while it is low is ignored.
- R4: In mode 2, vertical sync and horizontal sync falling in the same cycle start an odd field and a frame.
- R5: In mode 2, vertical sync falling while horizontal sync is high starts an even field. Vertical sync falling while horizontal sync stays low starts nothing.
- R6: In modes 1 and 3, a field pin level of 0 gives an odd field and 1 gives an even field. The frame strobe fires only together with the field strobe of an odd field. The odd flag changes only in the cycle its field strobe is high.
- R7: The line count rises by one on each horizontal sync fall and saturates at its maximum. It returns to zero on a frame start, and a frame start wins over a coincident horizontal sync fall.
- R8: With internal blanking selected, the active qualifier is low on lines whose count lies between the first and last blank line inclusive, and high otherwise.
- R9: With external blanking selected, the active qualifier is the inverse of the blanking pin, where high means blank.
- R10: The pixel-capture enable follows the active qualifier one clock later.
- R11: With the master bit set, no strobes are produced and the active qualifier stays low.
- R12: In mode 0 (timing carried by embedded codes), the sync pins produce no strobes.
- R13: A cycle with the write enable high loads the mode (2 bits, values 0 to 3), the master bit (1 = master) and the blank-select bit (1 = external pin). The new values govern decoding from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Timing mode 0..3 |
| cfg_master_i | input | 1 | 1 selects master (decoder idle) |
| cfg_blank_ext_i | input | 1 | 1 uses the blanking pin, 0 the internal window |
| blank_first_i | input | LINE_W | First blank line of internal window |
| blank_last_i | input | LINE_W | Last blank line of internal window |
| hs_i | input | 1 | Horizontal sync pin |
| vf_i | input | 1 | Vertical sync or field pin |
| blank_i | input | 1 | External blanking pin, high blanks |
| field_start_o | output | 1 | One-cycle field start strobe |
| frame_start_o | output | 1 | One-cycle frame start strobe |
| field_odd_o | output | 1 | Parity of the current field |
| active_o | output | 1 | Active video qualifier |
| pix_en_o | output | 1 | Pixel capture enable |

## Verification
The critical overlap is a frame start and a horizontal sync fall in the same cycle. In mode 2 both pins are dropped on one edge, so the line count must restart at zero rather than advance. The bench places the one-line blank window at line 2 and starts the coincidence with the count at 1. A design that lets the increment win lands on line 2 and drops the active qualifier, while a correct design stays active on line 0. A second overlap is a field pin change landing on the same edge as a configuration write. That cycle must still be decoded under the old mode, and the bench checks it on every mode switch.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        TM_CODE     = 2'd0,
        TM_FIELD_LO = 2'd1,
        TM_VSYNC    = 2'd2,
        TM_FIELD_HI = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   hs;
        logic   vf;
        tmode_e mode;
        logic   master;
        logic   blank_ext;
        logic   field_stb;
        logic   frame_stb;
        logic   odd;
        logic   active;
        logic   pix;
    } vsd_state_t;

    localparam vsd_state_t VSD_RESET = '{
        hs: 1'b0, vf: 1'b0, mode: TM_CODE, master: 1'b0, blank_ext: 1'b0,
        field_stb: 1'b0, frame_stb: 1'b0, odd: 1'b0, active: 1'b0, pix: 1'b0
    };

endpackage

// File: rtl/vsd_event.sv
module vsd_event
    import vsd_pkg::*;
(
    input  tmode_e mode_i,
    input  logic   hs_now_i,
    input  logic   vf_now_i,
    input  logic   hs_prev_i,
    input  logic   vf_prev_i,
    output logic   field_ev_o,
    output logic   frame_ev_o,
    output logic   odd_ev_o,
    output logic   hs_fall_o
);
    logic vf_chg;
    logic vs_fall;

    always_comb begin
        hs_fall_o  = hs_prev_i & ~hs_now_i;
        vf_chg     = vf_prev_i ^ vf_now_i;
        vs_fall    = vf_prev_i & ~vf_now_i;
        field_ev_o = 1'b0;
        odd_ev_o   = 1'b0;
        unique case (mode_i)
            TM_FIELD_LO: begin
                field_ev_o = vf_chg & ~hs_now_i;
                odd_ev_o   = ~vf_now_i;
            end
            TM_FIELD_HI: begin
                field_ev_o = vf_chg & hs_now_i;
                odd_ev_o   = ~vf_now_i;
            end
            TM_VSYNC: begin
                if (vs_fall && hs_fall_o) begin
                    field_ev_o = 1'b1;
                    odd_ev_o   = 1'b1;
                end else if (vs_fall && hs_now_i) begin
                    field_ev_o = 1'b1;
                    odd_ev_o   = 1'b0;
                end
            end
            default: begin
                field_ev_o = 1'b0;
                odd_ev_o   = 1'b0;
            end
        endcase
        frame_ev_o = field_ev_o & odd_ev_o;
    end

endmodule

// File: rtl/vsd_range.sv
module vsd_range #(
    parameter int W = 10
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic         inside_o
);
    always_comb begin
        inside_o = (val_i >= lo_i) && (val_i <= hi_i);
    end
endmodule

// File: rtl/vid_sync_slave.sv
module vid_sync_slave
    import vsd_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic              cfg_master_i,
    input  logic              cfg_blank_ext_i,
    input  logic [LINE_W-1:0] blank_first_i,
    input  logic [LINE_W-1:0] blank_last_i,
    input  logic              hs_i,
    input  logic              vf_i,
    input  logic              blank_i,
    output logic              field_start_o,
    output logic              frame_start_o,
    output logic              field_odd_o,
    output logic              active_o,
    output logic              pix_en_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    vsd_state_t        st_d, st_q;
    logic [LINE_W-1:0] line_d, line_q;

    logic ev_field, ev_frame, ev_odd, ev_hs_fall;
    logic in_blank;

    vsd_event u_event (
        .mode_i     (st_q.mode),
        .hs_now_i   (hs_i),
        .vf_now_i   (vf_i),
        .hs_prev_i  (st_q.hs),
        .vf_prev_i  (st_q.vf),
        .field_ev_o (ev_field),
        .frame_ev_o (ev_frame),
        .odd_ev_o   (ev_odd),
        .hs_fall_o  (ev_hs_fall)
    );

    vsd_range #(.W(LINE_W)) u_range (
        .val_i    (line_d),
        .lo_i     (blank_first_i),
        .hi_i     (blank_last_i),
        .inside_o (in_blank)
    );

    always_comb begin
        logic slave;
        st_d    = st_q;
        line_d  = line_q;
        slave   = ~st_q.master;

        st_d.hs = hs_i;
        st_d.vf = vf_i;

        if (cfg_we_i) begin
            st_d.mode      = tmode_e'(cfg_mode_i);
            st_d.master    = cfg_master_i;
            st_d.blank_ext = cfg_blank_ext_i;
        end

        st_d.field_stb = slave & ev_field;
        st_d.frame_stb = slave & ev_frame;
        if (slave && ev_field) begin
            st_d.odd = ev_odd;
        end

        if (slave) begin
            if (ev_frame) begin
                line_d = '0;
            end else if (ev_hs_fall && (line_q != LINE_MAX)) begin
                line_d = line_q + 1'b1;
            end
        end

        if (st_q.blank_ext) begin
            st_d.active = slave & ~blank_i;
        end else begin
            st_d.active = slave & ~in_blank;
        end

        st_d.pix = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= VSD_RESET;
            line_q <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    assign field_start_o = st_q.field_stb;
    assign frame_start_o = st_q.frame_stb;
    assign field_odd_o   = st_q.odd;
    assign active_o      = st_q.active;
    assign pix_en_o      = st_q.pix;

endmodule

// File: rtl/vid_sync_slave_chk.sv
module vid_sync_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic field_start,
    input logic frame_start,
    input logic field_odd,
    input logic active,
    input logic pix_en,
    input logic master_q
);
    // R6
    frame_with_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> field_start);

    // R6
    frame_is_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> field_odd);

    // R6
    odd_moves_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> (!$past(rst_n) || $stable(field_odd) || field_start));

    // R10
    pix_follows_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> pix_en);

    // R10
    pix_low_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pix_en);

    // R11
    master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_q |=> (!field_start && !frame_start && !active));

endmodule

bind vid_sync_slave vid_sync_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start_o),
    .frame_start (frame_start_o),
    .field_odd   (field_odd_o),
    .active      (active_o),
    .pix_en      (pix_en_o),
    .master_q    (st_q.master)
);

// File: tb/vid_sync_slave_bench.sv
module vid_sync_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 10;

    // each row: {hs, vf, field, frame, odd, active}, mode 1, blank window 0..1
    localparam logic [5:0] TBL [12] = '{
        6'b00_0000, 6'b01_1000, 6'b11_0000, 6'b01_0001,
        6'b10_0001, 6'b00_0001, 6'b01_1001, 6'b00_1110,
        6'b10_0010, 6'b00_0010, 6'b10_0010, 6'b00_0011
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_master = 1'b0;
    logic cfg_blank_ext = 1'b0;
    logic [LW-1:0] bfirst = 10'd0;
    logic [LW-1:0] blast = 10'd1;
    logic hs = 1'b1, vf = 1'b0, blk = 1'b0;
    logic field_start, frame_start, field_odd, active, pix_en;

    int checks = 0;
    int errors = 0;
    logic prev_a = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_sync_slave #(.LINE_W(LW)) u_vid_sync_slave (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_master_i(cfg_master),
        .cfg_blank_ext_i(cfg_blank_ext),
        .blank_first_i(bfirst), .blank_last_i(blast),
        .hs_i(hs), .vf_i(vf), .blank_i(blk),
        .field_start_o(field_start), .frame_start_o(frame_start),
        .field_odd_o(field_odd), .active_o(active), .pix_en_o(pix_en)
    );

    task automatic step(input logic h, input logic v, input logic b,
                        input logic [3:0] exp, input string req);
        logic [4:0] got, want;
        hs = h; vf = v; blk = b;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        got  = {field_start, frame_start, field_odd, active, pix_en};
        want = {exp, prev_a};
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %b expected %b (field,frame,odd,active,pix)", req, got, want);
        end
        prev_a = exp[0];
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic mst, input logic bx);
        cfg_we = 1'b1; cfg_mode = m; cfg_master = mst; cfg_blank_ext = bx;
    endtask

    task automatic check_reset(input string req);
        @(posedge clk);
        #1;
        checks++;
        if ({field_start, frame_start, field_odd, active, pix_en} !== 5'b0) begin
            errors++;
            $display("FAIL %s: got %b expected 00000", req,
                     {field_start, frame_start, field_odd, active, pix_en});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 outputs during reset
        check_reset("R1");
        check_reset("R1");
        rst_n = 1'b1;
        prev_a = 1'b0;

        // R13 write mode 1; this cycle still decodes in mode 0
        set_cfg(2'd1, 1'b0, 1'b0);
        step(1, 0, 0, 4'b0000, "R13");

        // R2 R6 R7 R8 R10 table in mode 1
        for (int i = 0; i < 12; i++) begin
            step(TBL[i][5], TBL[i][4], 1'b0, TBL[i][3:0], "R2 R6 R7 R8 R10 table");
        end

        // R3 mode 3
        set_cfg(2'd3, 1'b0, 1'b0);
        step(0, 0, 0, 4'b0011, "R13");
        step(1, 0, 0, 4'b0011, "R3");
        step(1, 1, 0, 4'b1001, "R3 even field, hs high");
        step(0, 0, 0, 4'b0001, "R3 change with hs low ignored");
        step(1, 1, 0, 4'b1001, "R3");
        step(1, 0, 0, 4'b1110, "R3 R6 odd frame");

        // R4 R5 R7 mode 2, one-line blank window at line 2
        bfirst = 10'd2; blast = 10'd2;
        set_cfg(2'd2, 1'b0, 1'b0);
        step(1, 0, 0, 4'b0011, "R8");
        step(1, 1, 0, 4'b0011, "R5 vs rise");
        step(0, 1, 0, 4'b0011, "R7 line 1");
        step(1, 1, 0, 4'b0011, "R7");
        step(0, 0, 0, 4'b1111, "R4 R7 coincident falls reset line");
        step(1, 1, 0, 4'b0011, "R4");
        step(0, 1, 0, 4'b0011, "R7 line 1");
        step(0, 0, 0, 4'b0011, "R5 vs fall with hs low ignored");
        step(1, 1, 0, 4'b0011, "R5");
        step(1, 0, 0, 4'b1001, "R5 even field");

        // R9 external blanking
        set_cfg(2'd2, 1'b0, 1'b1);
        step(1, 0, 1, 4'b0001, "R13 old blank select");
        step(1, 0, 1, 4'b0000, "R9 blank high");
        step(1, 0, 0, 4'b0001, "R9 blank low");
        step(1, 0, 1, 4'b0000, "R9 R10");

        // R11 master
        set_cfg(2'd2, 1'b1, 1'b1);
        step(1, 0, 0, 4'b0001, "R13");
        step(1, 1, 0, 4'b0000, "R11");
        step(0, 0, 0, 4'b0000, "R11 odd event suppressed");

        // R1 R12 reset again, mode 0 ignores pins
        rst_n = 1'b0;
        hs = 1'b1; vf = 1'b0; blk = 1'b0;
        check_reset("R1");
        check_reset("R1");
        rst_n = 1'b1;
        prev_a = 1'b0;
        step(1, 0, 0, 4'b0001, "R1");
        step(0, 0, 0, 4'b0001, "R12");
        step(0, 1, 0, 4'b0001, "R12 field pin change ignored");
        step(0, 0, 0, 4'b0001, "R12");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule